// File: doc/BRIEF.md
# Four-Word Byte-Lane Transposer

This block takes a stream of 32-bit words, each marked by a valid strobe, and gathers them into groups of four. It treats each group as a 4x4 matrix of bytes and emits that matrix transposed, as four 32-bit words. Output word k of a group holds byte k of every input word in the group. The byte taken from input word i sits in byte lane i of that output word.

Input words do not have to arrive back to back. Only cycles with the strobe high advance the position within the group. Two group buffers take turns: one fills while the other drains. A steady stream at one word per clock therefore comes out as a steady stream at one word per clock, and no data is lost. Both outputs come straight from flip-flops, so the block can sit on a timing-critical boundary.

Top module: `byte_lane_transposer`

## Requirements
- R1: Reset is synchronous and active low. While it is held, and at the first sampling point after it, data_out_valid is 0 and data_out is all zeros. The first valid word accepted after reset becomes word 0 of a new group.
- R2: A cycle with data_in_valid low is not counted toward a group. Gaps of any length between valid words leave the grouping and the output data unchanged.
- R3: In output word k of a group, byte lane i (bits 8i+7 down to 8i) equals byte k (bits 8k+7 down to 8k) of valid input word i of that group, for i and k from 0 to 3.
- R4: A group's four output words appear in ascending order of k. Word 0 carries the least significant input bytes and word 3 the most significant.
- R5: Word 0 of a group appears on the outputs two cycles after the cycle in which the group's fourth valid word is presented. data_out_valid then stays high for exactly four consecutive cycles for that group.
- R6: With data_in_valid held high continuously, groups are emitted back to back, in arrival order, with data_out_valid high on every cycle and no word lost.
- R7: An incomplete group produces no output, however long it waits. Its words are emitted only once its fourth valid word arrives.
- R8: While data_out_valid is low, data_out holds the last word emitted, or zero if no word has been emitted since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 32 | Input word, four bytes |
| data_in_valid | input | 1 | Marks data_in as a word to be accepted |
| data_out | output | 32 | Transposed output word, driven by a register |
| data_out_valid | output | 1 | Marks data_out as a transposed word, driven by a register |

## Verification
The assertions assume no back-pressure. The input side may present at most one word per cycle, and nothing can stall the output, so the owed-word count never exceeds two groups. The latency and burst properties also assume that reset is not asserted in the middle of a group while checking is active. The stimulus keeps to these assumptions. It drives at most one word per clock, mixes random gaps with runs at full rate, and asserts reset mid-group only after every owed word has been emitted.

// File: rtl/blt_pkg.sv
// Shared definitions for the byte-lane transposer.
// Assumes: bytes are 8 bits and exactly two group buffers are used.
package blt_pkg;
    localparam int BLT_BYTE_W = 8;
    localparam int BLT_LANES  = 4;

    // Identifies one of the two ping-pong group buffers.
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } blt_bank_e;
endpackage

// File: rtl/blt_bank.sv
// One group buffer: holds LANES input words, written one word at a time.
// All stored words are visible in parallel on rd_words, word i in slice i.
// Assumes: the writer never writes the buffer while it is being drained.
module blt_bank #(
    parameter int LANES  = blt_pkg::BLT_LANES,
    parameter int BYTE_W = blt_pkg::BLT_BYTE_W,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [LANES*WORD_W-1:0]   rd_words
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_word
            logic [WORD_W-1:0] word_q;

            // Capture the input word when this slot is addressed.
            always_ff @(posedge clk) begin
                if (we && (wr_idx == IDX_W'(g))) begin
                    word_q <= wr_data;
                end
            end

            assign rd_words[g*WORD_W +: WORD_W] = word_q;
        end
    endgenerate
endmodule

// File: rtl/blt_collector.sv
// Write side: counts valid input words, steers them into the filling buffer
// and, on the last word of a group, swaps buffers and raises a one-cycle
// group-done pulse naming the buffer just filled.
// Assumes: LANES is a power of two and at least 2.
module blt_collector #(
    parameter int LANES = blt_pkg::BLT_LANES,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [1:0]             bank_we,
    output logic                   done_q,
    output blt_pkg::blt_bank_e     done_sel
);
    import blt_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    blt_bank_e wr_sel;

    // Advance the slot counter on each valid word; swap buffers at group end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx   <= '0;
            wr_sel   <= BANK_A;
            done_q   <= 1'b0;
            done_sel <= BANK_A;
        end else begin
            done_q <= 1'b0;
            if (in_valid) begin
                if (wr_idx == LAST_IDX) begin
                    wr_idx   <= '0;
                    wr_sel   <= (wr_sel == BANK_A) ? BANK_B : BANK_A;
                    done_q   <= 1'b1;
                    done_sel <= wr_sel;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
        end
    end

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_we
            assign bank_we[b] = in_valid && (wr_sel == blt_bank_e'(b));
        end
    endgenerate
endmodule

// File: rtl/blt_emitter.sv
// Read side: on a group-done pulse, emits the transposed words of that
// buffer, one per cycle, from the output register. Word k, lane i takes
// byte k of stored word i.
// Assumes: group-done pulses are at least LANES cycles apart.
module blt_emitter #(
    parameter int LANES  = blt_pkg::BLT_LANES,
    parameter int BYTE_W = blt_pkg::BLT_BYTE_W,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  blt_pkg::blt_bank_e        start_sel,
    input  logic [LANES*WORD_W-1:0]   bank_a_words,
    input  logic [LANES*WORD_W-1:0]   bank_b_words,
    output logic [WORD_W-1:0]         out_data,
    output logic                      out_valid
);
    import blt_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    logic [IDX_W-1:0]        rd_idx;
    blt_bank_e               rd_sel;
    logic                    busy;
    blt_bank_e               cur_sel;
    logic [IDX_W-1:0]        cur_idx;
    logic [LANES*WORD_W-1:0] src;
    logic [WORD_W-1:0]       next_word;

    // Pick the buffer and byte row for the word about to be emitted.
    always_comb begin
        cur_sel = start ? start_sel : rd_sel;
        cur_idx = start ? '0 : rd_idx;
        src     = (cur_sel == BANK_B) ? bank_b_words : bank_a_words;
    end

    // Gather byte row cur_idx across all stored words into one word.
    always_comb begin
        next_word = '0;
        for (int i = 0; i < LANES; i++) begin
            next_word[i*BYTE_W +: BYTE_W] = src[i*WORD_W + int'(cur_idx)*BYTE_W +: BYTE_W];
        end
    end

    // Load the output register and step through the rows of a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx    <= '0;
            rd_sel    <= BANK_A;
            busy      <= 1'b0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (start || busy) begin
            out_data  <= next_word;
            out_valid <= 1'b1;
            if (start) begin
                rd_sel <= start_sel;
                rd_idx <= IDX_W'(1);
                busy   <= 1'b1;
            end else if (rd_idx == LAST_IDX) begin
                rd_idx <= '0;
                busy   <= 1'b0;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/byte_lane_transposer.sv
// Top: gathers valid input words into groups of LANES and emits each group
// transposed byte-wise, using two ping-pong buffers so that a group fills
// while the previous one drains. Outputs are register-driven.
// Assumes: no back-pressure; at most one input word per cycle.
module byte_lane_transposer #(
    parameter int LANES  = blt_pkg::BLT_LANES,
    parameter int BYTE_W = blt_pkg::BLT_BYTE_W,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data_in,
    input  logic              data_in_valid,
    output logic [WORD_W-1:0] data_out,
    output logic              data_out_valid
);
    import blt_pkg::*;

    logic [IDX_W-1:0]        wr_idx;
    logic [1:0]              bank_we;
    logic                    grp_done;
    blt_bank_e               grp_sel;
    logic [LANES*WORD_W-1:0] bank_words [2];

    blt_collector #(.LANES(LANES)) u_collector (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (data_in_valid),
        .wr_idx   (wr_idx),
        .bank_we  (bank_we),
        .done_q   (grp_done),
        .done_sel (grp_sel)
    );

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bank
            blt_bank #(.LANES(LANES), .BYTE_W(BYTE_W)) u_bank (
                .clk      (clk),
                .we       (bank_we[b]),
                .wr_idx   (wr_idx),
                .wr_data  (data_in),
                .rd_words (bank_words[b])
            );
        end
    endgenerate

    blt_emitter #(.LANES(LANES), .BYTE_W(BYTE_W)) u_emitter (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (grp_done),
        .start_sel    (grp_sel),
        .bank_a_words (bank_words[0]),
        .bank_b_words (bank_words[1]),
        .out_data     (data_out),
        .out_valid    (data_out_valid)
    );
endmodule

// File: rtl/blt_checker.sv
// Port-level checker for the byte-lane transposer, bound to the top.
// Keeps its own input-position, output-position and owed-word counters.
module blt_checker #(
    parameter int LANES  = blt_pkg::BLT_LANES,
    parameter int BYTE_W = blt_pkg::BLT_BYTE_W,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int IDX_W  = $clog2(LANES),
    localparam int OWE_W  = $clog2(2 * LANES + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_in_valid,
    input logic [WORD_W-1:0] data_out,
    input logic              data_out_valid
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    logic [IDX_W-1:0] in_pos;
    logic [IDX_W-1:0] out_pos;
    logic [OWE_W-1:0] owed;
    logic             grp_in;

    assign grp_in = data_in_valid && (in_pos == LAST_IDX);

    // Track group position at both edges and the words still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pos  <= '0;
            out_pos <= '0;
            owed    <= '0;
        end else begin
            if (data_in_valid) in_pos <= (in_pos == LAST_IDX) ? '0 : in_pos + 1'b1;
            if (data_out_valid) out_pos <= (out_pos == LAST_IDX) ? '0 : out_pos + 1'b1;
            owed <= owed + (grp_in ? OWE_W'(LANES) : '0) - (data_out_valid ? OWE_W'(1) : '0);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !data_out_valid); // R1
    AST_GROUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) grp_in |=> ##1 data_out_valid); // R5
    AST_WHOLE_BURST: assert property (@(posedge clk) disable iff (!rst_n) $fell(data_out_valid) |-> (out_pos == '0)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) data_out_valid |-> (owed != '0)); // R7
    AST_NO_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n) owed <= OWE_W'(2 * LANES)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !data_out_valid |-> $stable(data_out)); // R8
endmodule

bind byte_lane_transposer blt_checker #(.LANES(LANES), .BYTE_W(BYTE_W)) u_blt_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .data_in_valid  (data_in_valid),
    .data_out       (data_out),
    .data_out_valid (data_out_valid)
);

// File: tb/test_byte_lane_transposer.sv
// Self-checking bench: directed cases plus seeded random traffic, compared
// against a bench model of the group transpose and its output timing.
module test_byte_lane_transposer;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic        data_in_valid = 1'b0;
    logic [31:0] data_out;
    logic        data_out_valid;

    int n_vec = 0;
    int n_fail = 0;
    int cyc = 0;
    int mcnt = 0;
    string cur_tag = "R3";
    logic [31:0] grp [4];
    logic        exp_v [SLOTS];
    logic [31:0] exp_d [SLOTS];
    logic [31:0] last_d = '0;

    byte_lane_transposer i_byte_lane_transposer (
        .clk            (clk),
        .rst_n          (rst_n),
        .data_in        (data_in),
        .data_in_valid  (data_in_valid),
        .data_out       (data_out),
        .data_out_valid (data_out_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Transposed word k of the collected group, derived from R3.
    function automatic logic [31:0] xpose(input int k);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = grp[i][k*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // One clock: check this sampling slot, then drive the next input.
    task automatic step(input bit v, input logic [31:0] d, input bit rst);
        int s;
        @(negedge clk);
        s = cyc % SLOTS;
        chk(data_out_valid === exp_v[s], "R5 valid", 32'(data_out_valid), 32'(exp_v[s]));
        if (exp_v[s]) begin
            chk(data_out === exp_d[s], cur_tag, data_out, exp_d[s]);
            last_d = exp_d[s];
        end else begin
            chk(data_out === last_d, "R8 hold", data_out, last_d);
        end
        exp_v[s] = 1'b0;
        rst_n = !rst;
        data_in_valid = v && !rst;
        data_in = d;
        if (rst) begin
            mcnt = 0;
            last_d = '0;
        end else if (v) begin
            grp[mcnt] = d;
            mcnt++;
            if (mcnt == 4) begin
                for (int k = 0; k < 4; k++) begin
                    exp_v[(cyc + 2 + k) % SLOTS] = 1'b1;
                    exp_d[(cyc + 2 + k) % SLOTS] = xpose(k);
                end
                mcnt = 0;
            end
        end
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
        end
        void'($urandom(32'h0BADF00D));
        // R1: reset state, checked as zero valid and zero data
        cur_tag = "R1";
        repeat (4) step(1'b0, '0, 1'b1);
        repeat (3) step(1'b0, '0, 1'b0);
        // R4: distinct bytes show row order
        cur_tag = "R4";
        step(1'b1, 32'h03020100, 1'b0);
        step(1'b1, 32'h13121110, 1'b0);
        step(1'b1, 32'h23222120, 1'b0);
        // R7: partial group waits with no output
        repeat (12) step(1'b0, 32'hDEADBEEF, 1'b0);
        step(1'b1, 32'h33323130, 1'b0);
        repeat (8) step(1'b0, '0, 1'b0);
        // R6: full-rate stream of several groups
        cur_tag = "R6";
        for (int n = 0; n < 24; n++) step(1'b1, $urandom, 1'b0);
        repeat (8) step(1'b0, '0, 1'b0);
        // R1: reset mid-group drops the partial words
        cur_tag = "R1";
        step(1'b1, 32'hAAAAAAAA, 1'b0);
        step(1'b1, 32'hBBBBBBBB, 1'b0);
        repeat (3) step(1'b0, '0, 1'b1);
        for (int n = 0; n < 4; n++) step(1'b1, 32'h01010101 * (n + 5), 1'b0);
        repeat (8) step(1'b0, '0, 1'b0);
        // R2 / R3: random gaps and random data
        cur_tag = "R2 R3";
        for (int n = 0; n < 3000; n++) step(($urandom % 3) != 0, $urandom, 1'b0);
        repeat (10) step(1'b0, '0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule